// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block arbitrates the timing of external bus accesses issued by a single master toward four chip-select spaces. Each access is offered as a request carrying a space number (0 to 3) and a read/write flag. The block holds the request off until the required number of idle bus cycles has elapsed since the previous access. It then grants it, and drives the active-low chip select of the chosen space for a fixed number of cycles (`ACC_LEN`, default 2).

Two idle rules exist per space. An after-access count of 0 to 3 cycles applies when the next access goes to another space. A continuous-access count of 0 or 1 cycle applies when the next access returns to the same space, so that the chip select visibly rises between the two. A write that follows a read always waits the larger of the two counts. Idle cycles that have already passed without a request count toward the requirement. The rule fields come from one 16-bit configuration register. They are captured at the start of each access, together with that access's space and direction.

The request port follows valid/ready rules. `req_valid` and its payload (`req_space`, `req_write`) must stay stable until the cycle in which `req_ready` is high, and the access is accepted on that clock edge. `req_ready` may depend on the payload, because the idle requirement depends on the target space and direction. No request is dropped. Back-pressure lasts as long as the access in progress plus its idle requirement.

Top module: `bus_idle_gap`

## Requirements
- R1: After reset, `cfg_rdata` reads 16'hFFF0 (every after-access field 11, every continuous-access field 1), all `cs_n` bits are high and `busy` is low.
- R2: Configuration layout: after-access field of space 3 in bits 15:14, space 2 in 13:12, space 1 in 11:10 and space 0 in 9:8. Continuous-access bit of space 3 in bit 7, space 2 in 6, space 1 in 5 and space 0 in 4. Bits 3:0 read back as zero. A write with `cfg_we` high takes effect on the next edge.
- R3: An access is accepted on an edge where `req_valid` and `req_ready` are both high. From the next cycle, `cs_n[req_space]` alone is low for exactly `ACC_LEN` cycles. No other access can be accepted before the last of those cycles.
- R4: When the next access targets a different space and is not a write after a read, exactly the previous space's after-access count of idle cycles (00 to 11 meaning 0 to 3) lies between the two accesses, with all `cs_n` high.
- R5: When the next access targets the same space and is not a write after a read, the previous space's continuous-access bit gives the idle cycles. With 1, one cycle with that chip select high separates the accesses. With 0, the chip select stays low across both.
- R6: A write that immediately follows a read, to any space, is separated by the larger of the read space's after-access and continuous-access counts.
- R7: Idle cycles that elapse before the request is raised count toward the requirement. The grant is never later than the required count, and the first access after reset is granted at once.
- R8: The idle counts used for the next access are those of the configuration at the start of the previous access. A configuration write made after that start does not change the gap.
- R9: `busy` is high while any chip select is low and while a valid request is being held off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back |
| req_valid | input | 1 | Access request valid |
| req_space | input | 2 | Target chip-select space of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Request accepted on this edge when valid is high (grant) |
| cs_n | output | 4 | Active-low chip selects, bit n for space n |
| busy | output | 1 | Access in progress or request held off |

## Verification
The assertions take for granted that a raised request keeps its space and direction unchanged until it is granted. They also take for granted that the space number is always within 0 to 3. The bench drives every request at a falling edge and holds it, with its payload, until it sees `req_ready` high. It drops `req_valid` only after the accepting edge. Configuration writes are issued only while no request is pending, so a write never lands in the same cycle as a grant.

// File: rtl/bus_idle_pkg.sv
package bus_idle_pkg;
  localparam int NUM_CS  = 4;
  localparam int SEL_W   = 2;
  localparam int IW_W    = 2;
  localparam int CFG_W   = 16;
  localparam int IW_LSB  = 8;
  localparam int CW_LSB  = 4;
  localparam int SOFAR_W = IW_W + 1;

  localparam logic [CFG_W-1:0] CFG_MASK  = 16'hFFF0;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'hFFF0;

  function automatic logic [IW_W-1:0] after_field(logic [CFG_W-1:0] c, logic [SEL_W-1:0] s);
    return c[IW_LSB + IW_W*int'(s) +: IW_W];
  endfunction

  function automatic logic cont_field(logic [CFG_W-1:0] c, logic [SEL_W-1:0] s);
    return c[CW_LSB + int'(s)];
  endfunction
endpackage

// File: rtl/idle_cfg_reg.sv
module idle_cfg_reg
  import bus_idle_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (we_i) cfg_q <= wdata_i & CFG_MASK;
  end

  assign cfg_o = cfg_q;

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (cfg_o[CW_LSB-1:0] == '0) && (cfg_o[CFG_W-1:CW_LSB] == $past(wdata_i[CFG_W-1:CW_LSB])));
endmodule

// File: rtl/idle_access_ctrl.sv
module idle_access_ctrl
  import bus_idle_pkg::*;
#(
  parameter int ACC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_i,
  input  logic [SEL_W-1:0]  req_space_i,
  input  logic              req_write_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              in_access_o,
  output logic              acc_last_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              have_prev_o,
  output logic [SEL_W-1:0]  last_space_o,
  output logic              last_write_o,
  output logic [IW_W-1:0]   snap_iw_o,
  output logic              snap_cw_o
);
  localparam int CNT_W = (ACC_LEN > 1) ? $clog2(ACC_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_LEN - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] space_q;
  logic             write_q;
  logic             have_q;
  logic [IW_W-1:0]  iw_q;
  logic             cw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      space_q  <= '0;
      write_q  <= 1'b0;
      have_q   <= 1'b0;
      iw_q     <= '0;
      cw_q     <= 1'b0;
    end else if (grant_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_LOAD;
      space_q  <= req_space_i;
      write_q  <= req_write_i;
      have_q   <= 1'b1;
      iw_q     <= after_field(cfg_i, req_space_i);
      cw_q     <= cont_field(cfg_i, req_space_i);
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      assign cs_n_o[g] = !(active_q && (space_q == SEL_W'(g)));
    end
  endgenerate

  assign in_access_o  = active_q;
  assign acc_last_o   = active_q && (cnt_q == '0);
  assign have_prev_o  = have_q;
  assign last_space_o = space_q;
  assign last_write_o = write_q;
  assign snap_iw_o    = iw_q;
  assign snap_cw_o    = cw_q;

  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o));

  // R3
  cs_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |=> (!cs_n_o[$past(req_space_i)] && ($countones(~cs_n_o) == 1)));
endmodule

// File: rtl/idle_gap_cnt.sv
module idle_gap_cnt
  import bus_idle_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_access_i,
  input  logic             acc_last_i,
  input  logic             have_prev_i,
  input  logic [SEL_W-1:0] last_space_i,
  input  logic             last_write_i,
  input  logic [IW_W-1:0]  snap_iw_i,
  input  logic             snap_cw_i,
  input  logic [SEL_W-1:0] req_space_i,
  input  logic             req_write_i,
  output logic             ready_o
);
  localparam logic [IW_W-1:0] GAP_SAT = '1;

  logic [IW_W-1:0]    gap_q;
  logic [IW_W-1:0]    need;
  logic [IW_W-1:0]    cw_wide;
  logic [SOFAR_W-1:0] sofar;
  logic               turnaround;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= GAP_SAT;
    else if (in_access_i) gap_q <= '0;
    else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
  end

  always_comb begin
    cw_wide    = IW_W'(snap_cw_i);
    turnaround = !last_write_i && req_write_i;
    if (!have_prev_i) need = '0;
    else if (turnaround) need = (snap_iw_i > cw_wide) ? snap_iw_i : cw_wide;
    else if (req_space_i == last_space_i) need = cw_wide;
    else need = snap_iw_i;
  end

  assign sofar   = in_access_i ? '0 : (SOFAR_W'(gap_q) + 1'b1);
  assign ready_o = (!in_access_i || acc_last_i) && (sofar >= SOFAR_W'(need));

  // R3
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_access_i && !acc_last_i) |-> !ready_o);
endmodule

// File: rtl/bus_idle_gap.sv
module bus_idle_gap
  import bus_idle_pkg::*;
#(
  parameter int ACC_LEN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        req_valid,
  input  logic [1:0]  req_space,
  input  logic        req_write,
  output logic        req_ready,
  output logic [3:0]  cs_n,
  output logic        busy
);
  logic [CFG_W-1:0] cfg;
  logic             grant;
  logic             in_access, acc_last, have_prev, last_write, snap_cw;
  logic [SEL_W-1:0] last_space;
  logic [IW_W-1:0]  snap_iw;

  assign grant = req_valid && req_ready;

  idle_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .wdata_i (cfg_wdata),
    .cfg_o   (cfg)
  );

  idle_access_ctrl #(.ACC_LEN(ACC_LEN)) u_acc (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant_i      (grant),
    .req_space_i  (req_space),
    .req_write_i  (req_write),
    .cfg_i        (cfg),
    .in_access_o  (in_access),
    .acc_last_o   (acc_last),
    .cs_n_o       (cs_n),
    .have_prev_o  (have_prev),
    .last_space_o (last_space),
    .last_write_o (last_write),
    .snap_iw_o    (snap_iw),
    .snap_cw_o    (snap_cw)
  );

  idle_gap_cnt u_gap (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_access_i  (in_access),
    .acc_last_i   (acc_last),
    .have_prev_i  (have_prev),
    .last_space_i (last_space),
    .last_write_i (last_write),
    .snap_iw_i    (snap_iw),
    .snap_cw_i    (snap_cw),
    .req_space_i  (req_space),
    .req_write_i  (req_write),
    .ready_o      (req_ready)
  );

  assign cfg_rdata = cfg;
  assign busy      = in_access || (req_valid && !req_ready);

  // R4
  three_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && have_prev && (req_space != last_space) && (snap_iw == 2'b11))
      |-> ((cs_n == 4'hF) && ($past(cs_n) == 4'hF) && ($past(cs_n, 2) == 4'hF)));

  // R5
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && acc_last && (req_space == last_space)) |=> $stable(cs_n));

  // R6
  turn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && have_prev && !last_write && req_write && ((snap_iw != 2'b00) || snap_cw))
      |-> (cs_n == 4'hF));

  // R9
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 4'hF) |-> busy);
endmodule

// File: tb/test_bus_idle_gap.sv
`timescale 1ns/1ps
module test_bus_idle_gap;
  localparam int ACC_LEN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [1:0]  req_space = '0;
  logic        req_write = 1'b0;
  logic        req_ready;
  logic [3:0]  cs_n;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  int    exp_q[$];
  string tag_q[$];

  logic [15:0] m_cfg = 16'hFFF0;
  bit          m_have = 1'b0;
  int          m_space = 0;
  bit          m_write = 1'b0;
  int          m_iw = 0;
  int          m_cw = 0;
  int          prev_g = 0;

  bus_idle_gap #(.ACC_LEN(ACC_LEN)) i_bus_idle_gap (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_space(req_space),
    .req_write(req_write), .req_ready(req_ready), .cs_n(cs_n), .busy(busy)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic write_cfg(logic [15:0] d);
    cfg_we = 1'b1;
    cfg_wdata = d;
    m_cfg = d & 16'hFFF0;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk(cfg_rdata == m_cfg, "R2", "config read-back", cfg_rdata, m_cfg);
  endtask

  task automatic do_req(int sp, bit wr, int dly, string tag);
    int need, v, eg;
    if (dly > 0) repeat (dly) @(negedge clk);
    req_valid = 1'b1;
    req_space = sp[1:0];
    req_write = wr;
    v = cyc;
    if (m_have) begin
      need = (sp == m_space) ? m_cw : m_iw;
      if (!m_write && wr) need = (m_iw > m_cw) ? m_iw : m_cw;
      eg = prev_g + ACC_LEN + need;
      if (v > eg) eg = v;
      exp_q.push_back(eg - prev_g - ACC_LEN);
      tag_q.push_back(tag);
    end
    #1;
    if (!m_have) chk(req_ready == 1'b1, "R7", "first access ready", req_ready, 1);
    while (!req_ready) begin
      chk(busy == 1'b1, "R9", "busy while held", busy, 1);
      @(negedge clk);
      #1;
    end
    prev_g  = cyc;
    m_have  = 1'b1;
    m_space = sp;
    m_write = wr;
    m_iw    = int'(m_cfg[8 + 2*sp +: 2]);
    m_cw    = int'(m_cfg[4 + sp]);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: chip-select shape and grant spacing against the scoreboard
  int       mon_left = 0;
  int       mon_cur = 0;
  int       mon_last = 0;
  bit       mon_seen = 1'b0;
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      logic [3:0] exp_cs;
      exp_cs = (mon_left > 0) ? ~(4'b0001 << mon_cur) : 4'hF;
      chk(cs_n == exp_cs, "R3", "chip select pattern", cs_n, exp_cs);
      if (mon_left > 0) mon_left--;
      if (req_valid && req_ready) begin
        if (mon_seen) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected grant", cyc, -1);
          end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk((cyc - mon_last - ACC_LEN) == e, t, "idle cycles between accesses",
                cyc - mon_last - ACC_LEN, e);
          end
        end
        mon_seen = 1'b1;
        mon_last = cyc;
        mon_left = ACC_LEN;
        mon_cur  = int'(req_space);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cfg_rdata == 16'hFFF0, "R1", "reset config", cfg_rdata, 16'hFFF0);
    chk(cs_n == 4'hF, "R1", "reset chip selects", cs_n, 4'hF);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    @(negedge clk);

    do_req(0, 1'b0, 0, "R7");
    do_req(1, 1'b0, 0, "R4");
    do_req(1, 1'b0, 0, "R5");
    write_cfg(16'h279A);
    do_req(1, 1'b0, 0, "R8");
    do_req(1, 1'b0, 0, "R5");
    do_req(2, 1'b1, 0, "R6");
    do_req(2, 1'b0, 0, "R5");
    do_req(2, 1'b1, 0, "R6");
    do_req(3, 1'b0, 0, "R4");
    do_req(0, 1'b0, 5, "R7");
    do_req(1, 1'b0, 3, "R7");
    do_req(1, 1'b1, 0, "R6");
    do_req(0, 1'b0, 0, "R4");
    write_cfg(16'h2490);
    do_req(3, 1'b0, 0, "R8");
    do_req(3, 1'b0, 0, "R5");
    do_req(3, 1'b1, 0, "R6");
    do_req(0, 1'b0, 0, "R4");

    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "all expected grants seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule